// File: doc/BRIEF.md
# Packed Halfword SIMD Arithmetic Unit

This unit treats each 32-bit operand as two independent 16-bit lanes and applies one arithmetic operation to both lanes at once. The operations are wrapping add, wrapping subtract, scale-and-accumulate by a left shift, scale-and-accumulate by an arithmetic right shift, and a rounded unsigned mean. No carry or borrow crosses the seam between the lanes. Each lane has its own signed-overflow flag for add and subtract.

An operation is presented with `in_valid` high. The result, the flags and `out_valid` are registered and appear after the next rising clock edge. When `in_valid` is low, the registered outputs keep their values. Lane 0 occupies bits 15:0 and lane 1 occupies bits 31:16. Bit 0 of `ovf` belongs to lane 0.

Top module: `packed_simd_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `result`, `ovf` and `out_valid` are cleared to zero.
- R2: `out_valid` is high in the cycle after each cycle in which `in_valid` was high, and low after each cycle in which it was low. The result for an accepted operation is visible from that same edge.
- R3: When `in_valid` is low, `result` and `ovf` keep their previous values, whatever the other inputs do.
- R4: Op code 3'b000 gives each lane the sum a+b modulo 2^16. No carry passes from lane 0 (bits 15:0) to lane 1 (bits 31:16).
- R5: Op code 3'b001 gives each lane the difference a-b modulo 2^16. No borrow passes between lanes.
- R6: For op codes 3'b000 and 3'b001, `ovf[i]` is 1 exactly when the two's-complement result of lane i lies outside -32768..32767.
- R7: Op code 3'b010 gives each lane (a << shamt) + b modulo 2^16.
- R8: Op code 3'b011 gives each lane (a >>> shamt) + b modulo 2^16, where the right shift copies the lane's sign bit (bit 15 of the lane).
- R9: Op code 3'b100 gives each lane (a + b + 1) >> 1, computed without overflow on unsigned 16-bit lanes.
- R10: For op codes 3'b010 through 3'b111, `ovf` is 0. Op codes 3'b101, 3'b110 and 3'b111 give a result of 0.
- R11: A `shamt` of 0 applies no shift, so op codes 3'b010 and 3'b011 then equal a lane-wise add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation this cycle |
| op | input | 3 | Operation code |
| opa | input | 32 | First packed operand (the shifted one) |
| opb | input | 32 | Second packed operand |
| shamt | input | 2 | Shift amount for scale-and-accumulate |
| out_valid | output | 1 | Registered result is new |
| result | output | 32 | Registered packed result |
| ovf | output | 2 | Per-lane signed overflow, bit 0 = lane 0 |

## Verification
Two things can happen to lane 0 in the same cycle: its sum wraps out of bit 15, and its overflow flag changes. The carry that wraps must not show up in lane 1. The bench provokes this with operands whose low lanes produce a carry-out with and without signed overflow, while the high lanes hold values chosen so that a leaked carry would change them by one. It then judges both lanes and both flags against a model that works in plain integers.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_SHLA = 3'b010,
    OP_SHRA = 3'b011,
    OP_AVG  = 3'b100
  } simd_op_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int LANE_W = 16,
  parameter int SH_W   = 2
) (
  input  logic [2:0]        op,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [SH_W-1:0]   shamt,
  output logic [LANE_W-1:0] res,
  output logic              ovf
);
  import simd_pkg::*;
  localparam int MSB = LANE_W - 1;

  logic [LANE_W-1:0] sum_w, dif_w, shl_w, shr_w, avg_w;

  assign sum_w = a + b;
  assign dif_w = a - b;
  assign shl_w = (a << shamt) + b;
  assign shr_w = LANE_W'($signed(a) >>> shamt) + b;
  assign avg_w = LANE_W'(({1'b0, a} + {1'b0, b} + (LANE_W+1)'(1)) >> 1);

  always_comb begin
    res = '0;
    ovf = 1'b0;
    case (simd_op_e'(op))
      OP_ADD: begin
        res = sum_w;
        ovf = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
      end
      OP_SUB: begin
        res = dif_w;
        ovf = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
      end
      OP_SHLA: res = shl_w;
      OP_SHRA: res = shr_w;
      OP_AVG:  res = avg_w;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/simd_out_reg.sv
module simd_out_reg #(
  parameter int WORD_W = 32,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] d_res,
  input  logic [LANES-1:0]  d_ovf,
  output logic              q_vld,
  output logic [WORD_W-1:0] q_res,
  output logic [LANES-1:0]  q_ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q_res <= '0;
      q_ovf <= '0;
    end else begin
      q_vld <= load;
      if (load) begin
        q_res <= d_res;
        q_ovf <= d_ovf;
      end
    end
  end
endmodule

// File: rtl/packed_simd_alu.sv
module packed_simd_alu #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 16,
  parameter int SH_W   = 2,
  localparam int LANES = WORD_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic [SH_W-1:0]   shamt,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic [LANES-1:0]  ovf
);
  logic [WORD_W-1:0] nxt_res;
  logic [LANES-1:0]  nxt_ovf;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    simd_lane #(.LANE_W(LANE_W), .SH_W(SH_W)) u_lane (
      .op    (op),
      .a     (opa[i*LANE_W +: LANE_W]),
      .b     (opb[i*LANE_W +: LANE_W]),
      .shamt (shamt),
      .res   (nxt_res[i*LANE_W +: LANE_W]),
      .ovf   (nxt_ovf[i])
    );
  end

  simd_out_reg #(.WORD_W(WORD_W), .LANES(LANES)) u_oreg (
    .clk   (clk),
    .rst   (rst),
    .load  (in_valid),
    .d_res (nxt_res),
    .d_ovf (nxt_ovf),
    .q_vld (out_valid),
    .q_res (result),
    .q_ovf (ovf)
  );
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 16,
  parameter int SH_W   = 2,
  localparam int LANES = WORD_W / LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [WORD_W-1:0] opa,
  input logic [WORD_W-1:0] opb,
  input logic [SH_W-1:0]   shamt,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic [LANES-1:0]  ovf
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && ovf == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(ovf)));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[2:1] != 2'b00) |=> (ovf == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R4
    add_lane_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == 3'b000) |=>
        (result[i*LANE_W +: LANE_W] ==
         $past(opa[i*LANE_W +: LANE_W] + opb[i*LANE_W +: LANE_W])));
    // R11
    zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op[2:1] == 2'b01 && shamt == '0) |=>
        (result[i*LANE_W +: LANE_W] ==
         $past(opa[i*LANE_W +: LANE_W] + opb[i*LANE_W +: LANE_W])));
  end
endmodule

bind packed_simd_alu simd_alu_chk #(.WORD_W(WORD_W), .LANE_W(LANE_W), .SH_W(SH_W)) u_chk (.*);

// File: tb/sim_packed_simd_alu.sv
module sim_packed_simd_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [1:0]  shamt = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [1:0]  ovf;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  packed_simd_alu u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_res(logic [2:0] o, logic [31:0] a, logic [31:0] b, int s);
    logic [31:0] r = '0;
    for (int i = 0; i < 2; i++) begin
      int ua = int'(a[16*i +: 16]);
      int ub = int'(b[16*i +: 16]);
      int sa = (ua >= 32768) ? ua - 65536 : ua;
      int v = 0;
      case (o)
        3'd0: v = ua + ub;
        3'd1: v = ua - ub;
        3'd2: v = ua * (1 << s) + ub;
        3'd3: v = (sa >>> s) + ub;
        3'd4: v = (ua + ub + 1) / 2;
        default: v = 0;
      endcase
      r[16*i +: 16] = 16'(v);
    end
    return r;
  endfunction

  function automatic logic [1:0] m_ovf(logic [2:0] o, logic [31:0] a, logic [31:0] b);
    logic [1:0] f = '0;
    for (int i = 0; i < 2; i++) begin
      int sa = int'($signed(a[16*i +: 16]));
      int sb = int'($signed(b[16*i +: 16]));
      int v = (o == 3'd0) ? sa + sb : sa - sb;
      if (o <= 3'd1) f[i] = (v > 32767) || (v < -32768);
    end
    return f;
  endfunction

  task automatic run(string req, logic [2:0] o, logic [31:0] a, logic [31:0] b, logic [1:0] s);
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b; shamt = s;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, result, m_res(o, a, b, int'(s)));
    chk({req, " ovf R6 R10"}, {30'd0, ovf}, {30'd0, m_ovf(o, a, b)});
    chk("R2 valid", {31'd0, out_valid}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 result", result, 32'd0);
    chk("R1 ovf", {30'd0, ovf}, 32'd0);
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_add();
    run("R4 add", 3'd0, 32'h1234_5678, 32'h1111_2222, 2'd0);
    run("R4 add lane carry isolated", 3'd0, 32'h0000_FFFF, 32'h0000_0001, 2'd0);
    run("R4 R6 add both lanes", 3'd0, 32'h7FFF_8000, 32'h0001_8000, 2'd0);
    run("R6 add low overflow only", 3'd0, 32'h1000_7FFF, 32'h2000_0001, 2'd0);
  endtask

  task automatic t_sub();
    run("R5 sub", 3'd1, 32'h5000_0003, 32'h1000_0001, 2'd0);
    run("R5 sub borrow isolated", 3'd1, 32'h0001_0000, 32'h0000_0001, 2'd0);
    run("R5 R6 sub overflow", 3'd1, 32'h7FFF_8000, 32'hFFFF_0001, 2'd0);
  endtask

  task automatic t_shift();
    run("R7 shla 1", 3'd2, 32'h0003_0005, 32'h0001_0010, 2'd1);
    run("R7 shla 3 wrap", 3'd2, 32'hF000_1234, 32'h0001_0001, 2'd3);
    run("R8 shra neg", 3'd3, 32'h8000_FFF0, 32'h0000_0004, 2'd2);
    run("R8 shra pos", 3'd3, 32'h7FF8_0040, 32'h0001_0000, 2'd3);
    run("R11 shla zero", 3'd2, 32'h1234_FFFF, 32'h4321_0001, 2'd0);
    run("R11 shra zero", 3'd3, 32'h8001_0002, 32'h0001_0003, 2'd0);
  endtask

  task automatic t_avg();
    run("R9 avg max", 3'd4, 32'hFFFF_0001, 32'hFFFF_0002, 2'd0);
    run("R9 avg round", 3'd4, 32'h8000_0000, 32'h0001_0000, 2'd0);
  endtask

  task automatic t_unused();
    run("R10 op5", 3'd5, 32'hFFFF_FFFF, 32'h7FFF_7FFF, 2'd1);
    run("R10 op7", 3'd7, 32'h1234_5678, 32'h8765_4321, 2'd3);
  endtask

  task automatic t_hold();
    logic [31:0] keep;
    run("R3 setup", 3'd0, 32'h7FFF_0001, 32'h0001_0001, 2'd0);
    keep = result;
    @(negedge clk);
    op = 3'd1; opa = 32'hAAAA_5555; opb = 32'h1234_4321; shamt = 2'd2;
    @(negedge clk);
    chk("R3 hold result", result, keep);
    chk("R3 hold ovf", {30'd0, ovf}, 32'd2);
    chk("R2 valid low", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_add();
    t_sub();
    t_shift();
    t_avg();
    t_unused();
    t_hold();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule